// File: doc/BRIEF.md
# Prescaled Periodic Loop Timer

This block paces the speed and position control loops of an encoder interface. A 16-bit timer register counts down at a rate set by an 8-bit prescale value. When it has counted through zero, it reloads from a 16-bit period register and raises a one-clock interrupt pulse. The interrupt period is therefore (period + 1) × (scale + 1) system clocks. With scale 0 this gives 1 to 65,536 clocks, and with scale 255 it reaches 256 × 65,536 clocks.

A host programs the block through a small write port. The control word holds a run bit and a snapshot-source bit. The snapshot strobe tells the neighbouring position-count and event-timer logic when to freeze its registers. The source bit chooses between two triggers: every timeout, or every host read of the position count, which arrives on a strobe input. Interrupt masking and the snapshot registers live outside this block.

Top module: `enc_loop_timer`

## Requirements
- R1: After synchronous reset the timer register, period, scale and control word are zero, and `irq_pulse` and `snap_strobe` are low.
- R2: While running with scale S, the timer register drops by one once every S+1 clocks. The first drop comes S+1 clocks after the prescaler was last cleared.
- R3: A prescaler tick that finds the timer register at zero reloads it from the period register instead of decrementing. In the clock that shows the reloaded value, `irq_pulse` is high for that one clock only.
- R4: Clearing the run bit freezes both the timer register and the prescaler count, with no interrupts. Setting the run bit again resumes from the frozen prescaler count.
- R5: A write to the timer address loads the written value at once and clears the prescaler. The next decrement follows S+1 clocks later, and the write wins over a tick in the same clock.
- R6: A write to the period address does not disturb the count in progress. It is used at the next reload.
- R7: With the snapshot-source bit set, `snap_strobe` pulses in exactly the clocks where `irq_pulse` pulses, and `cnt_rd_stb` is ignored.
- R8: With the snapshot-source bit clear, `snap_strobe` pulses one clock after each cycle in which `cnt_rd_stb` is high, and timeouts produce no strobe.
- R9: While the run bit is clear, `irq_pulse` stays low even when the timer register holds zero.
- R10: The address map is: 0 control (bit 5 run, bit 4 snapshot on timeout), 1 timer, 2 period, 3 scale. Only the low 8 bits of the scale word are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host write address |
| wr_data | input | 16 | Host write data |
| cnt_rd_stb | input | 1 | High for one clock when the host reads the position count |
| timer_q | output | 16 | Current timer register value |
| irq_pulse | output | 1 | One-clock loop interrupt on each reload |
| snap_strobe | output | 1 | One-clock snapshot trigger for the position and event-timer registers |

## Verification
The main countdown is tried with scale 0, 1, 2 and 3, with period values from 1 to 20, and with starting counts loaded both before and during a run. The different scales separate a correct (S+1)-clock pace from off-by-one pacing. A scale word with upper bits set shows whether only the low byte is used. A timer write issued in the middle of a prescale interval tells apart a design that clears the prescaler from one that keeps it. A period write made mid-count shows whether the reload value is sampled early or late. Pausing with a partly advanced prescaler tells a true freeze from a restart. Both snapshot modes are run, including a count-read strobe that lands on a timeout clock, to separate the two strobe sources.

// File: rtl/lptmr_pkg.sv
package lptmr_pkg;

    localparam int HOST_W     = 16;
    localparam int TIMER_W    = 16;
    localparam int SCALE_W    = 8;
    localparam int REG_AW     = 2;

    localparam int CTRL_RUN_BIT  = 5;
    localparam int CTRL_SNAP_BIT = 4;

    typedef enum logic [REG_AW-1:0] {
        SEL_CTRL   = 2'd0,
        SEL_TIMER  = 2'd1,
        SEL_PERIOD = 2'd2,
        SEL_SCALE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic run;
        logic snap_on_tmo;
    } ctrl_t;

    function automatic logic sel_hit(logic en, logic [REG_AW-1:0] addr, reg_sel_e sel);
        return en && (reg_sel_e'(addr) == sel);
    endfunction

endpackage

// File: rtl/lptmr_regs.sv
module lptmr_regs
    import lptmr_pkg::*;
#(
    parameter int DATA_W = HOST_W,
    parameter int TMR_W  = TIMER_W,
    parameter int SCL_W  = SCALE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic [TMR_W-1:0]  period,
    output logic [SCL_W-1:0]  scale,
    output logic              timer_ld,
    output logic [TMR_W-1:0]  timer_ld_val
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            period <= '0;
            scale  <= '0;
        end else begin
            if (sel_hit(wr_en, wr_addr, SEL_CTRL)) begin
                ctrl.run         <= wr_data[CTRL_RUN_BIT];
                ctrl.snap_on_tmo <= wr_data[CTRL_SNAP_BIT];
            end
            if (sel_hit(wr_en, wr_addr, SEL_PERIOD))
                period <= wr_data[TMR_W-1:0];
            if (sel_hit(wr_en, wr_addr, SEL_SCALE))
                scale <= wr_data[SCL_W-1:0];
        end
    end

    assign timer_ld     = sel_hit(wr_en, wr_addr, SEL_TIMER);
    assign timer_ld_val = wr_data[TMR_W-1:0];

    AST_SCALE_LOW_BYTE: assert property (@(posedge clk) disable iff (rst)
        sel_hit(wr_en, wr_addr, SEL_SCALE) |=> scale == $past(wr_data[SCL_W-1:0])); // R10

endmodule

// File: rtl/lptmr_prescale.sv
module lptmr_prescale #(
    parameter int SCL_W = lptmr_pkg::SCALE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [SCL_W-1:0] scale,
    output logic             tick
);

    logic [SCL_W-1:0] pcnt;

    // >= keeps the divider safe if scale is lowered below the running count
    assign tick = run && (pcnt >= scale);

    always_ff @(posedge clk) begin
        if (rst)
            pcnt <= '0;
        else if (restart)
            pcnt <= '0;
        else if (tick)
            pcnt <= '0;
        else if (run)
            pcnt <= pcnt + 1'b1;
    end

    AST_PRESCALE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !run && !restart |=> $stable(pcnt)); // R4

    AST_PRESCALE_RESTART: assert property (@(posedge clk) disable iff (rst)
        restart |=> pcnt == '0); // R5

endmodule

// File: rtl/lptmr_core.sv
module lptmr_core #(
    parameter int TMR_W = lptmr_pkg::TIMER_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             ld,
    input  logic [TMR_W-1:0] ld_val,
    input  logic [TMR_W-1:0] period,
    output logic [TMR_W-1:0] timer_q,
    output logic             tmo_now,
    output logic             tmo_q
);

    logic at_zero;

    assign at_zero = (timer_q == '0);
    assign tmo_now = tick && !ld && at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            timer_q <= '0;
            tmo_q   <= 1'b0;
        end else begin
            tmo_q <= tmo_now;
            if (ld)
                timer_q <= ld_val;
            else if (tick)
                timer_q <= at_zero ? period : timer_q - 1'b1;
        end
    end

    AST_DECREMENT_STEP: assert property (@(posedge clk) disable iff (rst)
        tick && !ld && timer_q != '0 |=> timer_q == $past(timer_q) - 1'b1); // R2

    AST_RELOAD_PERIOD: assert property (@(posedge clk) disable iff (rst)
        tmo_q |-> timer_q == $past(period)); // R3

    AST_TMO_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
        tmo_q |-> $past(timer_q) == '0); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !tick && !ld |=> $stable(timer_q)); // R4

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        ld |=> timer_q == $past(ld_val) && !tmo_q); // R5

endmodule

// File: rtl/enc_loop_timer.sv
module enc_loop_timer
    import lptmr_pkg::*;
#(
    parameter int DATA_W = HOST_W,
    parameter int TMR_W  = TIMER_W,
    parameter int SCL_W  = SCALE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cnt_rd_stb,
    output logic [TMR_W-1:0]  timer_q,
    output logic              irq_pulse,
    output logic              snap_strobe
);

    ctrl_t            ctrl;
    logic [TMR_W-1:0] period;
    logic [SCL_W-1:0] scale;
    logic             timer_ld;
    logic [TMR_W-1:0] timer_ld_val;
    logic             tick;
    logic             tmo_now;
    logic             snap_q;

    lptmr_regs #(.DATA_W(DATA_W), .TMR_W(TMR_W), .SCL_W(SCL_W)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .ctrl         (ctrl),
        .period       (period),
        .scale        (scale),
        .timer_ld     (timer_ld),
        .timer_ld_val (timer_ld_val)
    );

    lptmr_prescale #(.SCL_W(SCL_W)) u_prescale (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl.run),
        .restart (timer_ld),
        .scale   (scale),
        .tick    (tick)
    );

    lptmr_core #(.TMR_W(TMR_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .ld      (timer_ld),
        .ld_val  (timer_ld_val),
        .period  (period),
        .timer_q (timer_q),
        .tmo_now (tmo_now),
        .tmo_q   (irq_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst)
            snap_q <= 1'b0;
        else
            snap_q <= ctrl.snap_on_tmo ? tmo_now : cnt_rd_stb;
    end

    assign snap_strobe = snap_q;

    AST_SNAP_ON_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        ctrl.snap_on_tmo && tmo_now |=> snap_strobe && irq_pulse); // R7

    AST_SNAP_ONLY_WITH_IRQ: assert property (@(posedge clk) disable iff (rst)
        ctrl.snap_on_tmo && !tmo_now |=> !snap_strobe); // R7

    AST_SNAP_ON_READ: assert property (@(posedge clk) disable iff (rst)
        !ctrl.snap_on_tmo && cnt_rd_stb |=> snap_strobe); // R8

    AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run |=> !irq_pulse); // R9

endmodule

// File: tb/tb_enc_loop_timer.sv
module tb_enc_loop_timer;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        cnt_rd_stb = 1'b0;
    logic [15:0] timer_q;
    logic        irq_pulse;
    logic        snap_strobe;

    int unsigned cyc = 0;
    int checks = 0;
    int fails  = 0;
    bit done = 1'b0;

    typedef struct {
        int unsigned cyc;
        bit          irq;
        bit          snap;
        logic [15:0] tval;
        string       tag;
    } exp_t;

    exp_t expq[$];

    enc_loop_timer dut (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .cnt_rd_stb  (cnt_rd_stb),
        .timer_q     (timer_q),
        .irq_pulse   (irq_pulse),
        .snap_strobe (snap_strobe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Monitor: pops expected pulses as the design produces them
    always @(negedge clk) begin
        if (!rst && (irq_pulse || snap_strobe)) begin
            if (expq.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R3/R7/R8/R9 unexpected pulse: actual irq=%0b snap=%0b expected none (cycle %0d)",
                         irq_pulse, snap_strobe, cyc);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk(e.tag, "pulse cycle", cyc, e.cyc);
                chk(e.tag, "irq_pulse", irq_pulse, e.irq);
                chk(e.tag, "snap_strobe", snap_strobe, e.snap);
                if (e.irq) chk(e.tag, "reloaded timer", timer_q, e.tval);
            end
        end
    end

    always @(negedge clk) begin
        if (!done && cyc > WATCHDOG) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WATCHDOG);
            report();
        end
    end

    // All tasks start and end at a falling edge; an input set there is taken at edge cyc+1
    task automatic hwrite(input logic [1:0] a, input logic [15:0] d, output int unsigned edge_no);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        edge_no = cyc + 1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_pulse();
        cnt_rd_stb = 1'b1;
        @(negedge clk);
        cnt_rd_stb = 1'b0;
    endtask

    task automatic wait_cyc(int unsigned n);
        while (cyc < n) @(negedge clk);
    endtask

    // Timeouts from a cleared prescaler at edge base with count t, period p, scale s
    task automatic push_tmo(int unsigned base, int unsigned t, int unsigned p, int unsigned s,
                            int n, bit snap, string tag);
        int unsigned at;
        at = base + (t + 1) * (s + 1);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.cyc = at; e.irq = 1'b1; e.snap = snap; e.tval = p[15:0]; e.tag = tag;
            expq.push_back(e);
            at += (p + 1) * (s + 1);
        end
    endtask

    task automatic drain(string tag);
        repeat (6) @(negedge clk);
        chk(tag, "pending expected pulses", expq.size(), 0);
        expq.delete();
    endtask

    initial begin
        int unsigned c, w, r, x;
        repeat (3) @(negedge clk);
        chk("R1", "timer after reset", timer_q, 0);
        chk("R1", "irq after reset", irq_pulse, 0);
        chk("R1", "snap after reset", snap_strobe, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "timer out of reset", timer_q, 0);

        // A: scale 0, snapshot on timeout; read strobe ignored (R2, R3, R7)
        hwrite(2'd3, 16'd0, x);
        hwrite(2'd2, 16'd3, x);
        hwrite(2'd1, 16'd2, x);
        hwrite(2'd0, 16'h0030, c);
        push_tmo(c, 2, 3, 0, 4, 1'b1, "R3_R7");
        wait_cyc(c + 1); chk("R2", "scale0 first step", timer_q, 1);
        wait_cyc(c + 2); chk("R2", "scale0 second step", timer_q, 0);
        wait_cyc(c + 4); rd_pulse();                 // R7: no strobe expected at c+5
        wait_cyc(c + 15);
        hwrite(2'd0, 16'h0000, x);
        drain("R7");

        // B: scale word with high bits set, scale 2 (R10, R2)
        hwrite(2'd3, 16'h0302, x);
        hwrite(2'd2, 16'd1, x);
        hwrite(2'd1, 16'd4, x);
        hwrite(2'd0, 16'h0030, c);
        push_tmo(c, 4, 1, 2, 3, 1'b1, "R10_R3");
        wait_cyc(c + 2); chk("R2", "scale2 hold", timer_q, 4);
        wait_cyc(c + 3); chk("R10", "scale2 step", timer_q, 3);
        wait_cyc(c + 27);
        hwrite(2'd0, 16'h0000, x);
        drain("R10");

        // C: pause with the prescaler part way, then resume (R4)
        hwrite(2'd3, 16'd1, x);
        hwrite(2'd2, 16'd9, x);
        hwrite(2'd1, 16'd6, x);
        hwrite(2'd0, 16'h0030, c);
        wait_cyc(c + 4);
        hwrite(2'd0, 16'h0000, x);
        wait_cyc(c + 15); chk("R4", "frozen timer", timer_q, 4);
        wait_cyc(c + 25); chk("R4", "still frozen", timer_q, 4);
        hwrite(2'd0, 16'h0030, r);
        push_tmo(r - 1, 4, 9, 1, 2, 1'b1, "R4_R3");
        wait_cyc(r + 1); chk("R4", "prescaler resumed", timer_q, 3);
        wait_cyc(r + 29);
        hwrite(2'd0, 16'h0000, x);
        drain("R4");

        // D: timer write mid-interval, then period write mid-count (R5, R6)
        hwrite(2'd3, 16'd3, x);
        hwrite(2'd2, 16'd20, x);
        hwrite(2'd1, 16'd10, x);
        hwrite(2'd0, 16'h0030, c);
        wait_cyc(c + 1);
        hwrite(2'd1, 16'd7, w);
        push_tmo(w, 7, 2, 3, 2, 1'b1, "R6_R3");
        chk("R5", "timer loaded", timer_q, 7);
        wait_cyc(w + 3); chk("R5", "prescaler cleared", timer_q, 7);
        wait_cyc(w + 4); chk("R5", "first step after load", timer_q, 6);
        wait_cyc(w + 9);
        hwrite(2'd2, 16'd2, x);
        wait_cyc(w + 11); chk("R6", "count undisturbed", timer_q, 5);
        wait_cyc(w + 44);
        hwrite(2'd0, 16'h0000, x);
        drain("R6");

        // E: snapshot on count read (R8)
        hwrite(2'd3, 16'd0, x);
        hwrite(2'd2, 16'd4, x);
        hwrite(2'd1, 16'd1, x);
        hwrite(2'd0, 16'h0020, c);
        begin
            exp_t e;
            e = '{c + 2,  1'b1, 1'b0, 16'd4, "R8_R3"}; expq.push_back(e);
            e = '{c + 4,  1'b0, 1'b1, 16'd0, "R8"};    expq.push_back(e);
            e = '{c + 7,  1'b1, 1'b1, 16'd4, "R8"};    expq.push_back(e);
            e = '{c + 12, 1'b1, 1'b0, 16'd4, "R8_R3"}; expq.push_back(e);
        end
        wait_cyc(c + 3); rd_pulse();
        wait_cyc(c + 6); rd_pulse();
        wait_cyc(c + 12);
        hwrite(2'd0, 16'h0000, x);
        drain("R8");

        // F: stopped with a zero count (R9)
        hwrite(2'd1, 16'd0, x);
        repeat (20) @(negedge clk);
        chk("R9", "idle timer stays zero", timer_q, 0);
        chk("R9", "no irq while stopped", irq_pulse, 0);
        drain("R9");

        done = 1'b1;
        report();
    end

endmodule